// File: doc/BRIEF.md
# Packet Discard Statistics Bank

This block keeps running statistics on camera packets that an upstream receiver has dropped. It has one independent slot per discard cause. With the default of four slots, slot 0 counts overflow discards, slot 1 length-limit discards, slot 2 unmatched discards and slot 3 inactive-channel discards. Upstream logic raises a slot's event strobe for one cycle for each discard. With the strobe it presents the size of the dropped data, the packet's 6-bit data type and its 2-bit virtual channel. The slot adds the size into a saturating 24-bit total and records the data type and virtual channel of the most recent discard.

Each slot appears as one 32-bit word that software can read directly. The total sits in bits 23:0, the latest data type in bits 29:24 and the latest virtual channel in bits 31:30. Software reads the word and then writes zero to it to start a new measurement period. Each slot also sends a one-cycle pulse toward the interrupt status logic for every discard it accepts.

Top module: `discard_stat_bank`

## Requirements
- R1: After reset, every statistics word is 0 and every event pulse output is low.
- R2: An event on a slot adds its amount (zero-extended) to bits 23:0 of that slot's word; the new total is visible on the clock edge that samples the event.
- R3: An event on a slot loads its data type into bits 29:24 and its virtual channel into bits 31:30, replacing the earlier values.
- R4: The total saturates at 0xFFFFFF. A sum above that value gives 0xFFFFFF and never wraps; a sum of exactly 0xFFFFFF is stored as is.
- R5: A write strobe with data zero to the slot chosen by the select input clears all 32 bits of that slot on the next edge.
- R6: A write with nonzero data leaves the selected slot unchanged.
- R7: When a clearing write and an event reach the same slot in the same cycle, the slot loads the event's amount, data type and virtual channel, discarding the old total.
- R8: Every accepted event raises that slot's pulse output for exactly the one cycle after the sampling edge. Without an event the pulse stays low.
- R9: Slots are independent. An event or write aimed at one slot never changes another slot's word or pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 4 | Per-slot discard strobe, one bit per slot (0 overflow, 1 length limit, 2 unmatched, 3 inactive) |
| evtAmount | input | 4x16 | Per-slot size of the dropped data |
| evtDataType | input | 4x6 | Per-slot data type of the dropped packet |
| evtVirtChan | input | 4x2 | Per-slot virtual channel of the dropped packet |
| wrEn | input | 1 | Software write strobe |
| wrSel | input | 2 | Slot index addressed by the write |
| wrData | input | 32 | Write data; only zero has an effect |
| statRegs | output | 4x32 | Per-slot statistics word {vc, dt, total} |
| statEvent | output | 4 | Per-slot one-cycle discard pulse |

## Verification
The in-RTL properties check the following on every cycle:
- totals that only grow between clears;
- capture of the type and channel from the previous cycle's event;
- a zero word after a lone clear;
- the restart value when a clear and an event coincide;
- the pulse tracking its event;
- the stability of a slot under a nonzero write or a write aimed at a sibling slot.

The exact saturation boundary can only be shown by the bench's directed scenarios, which drive a total to exactly 0xFFFFFF and then past it. The same holds for the full packed word layout seen by software and for the reset values, which the bench compares against an independent model.

// File: rtl/discard_pkg.sv
package discard_pkg;

  // Slot indices; the order is the index used on wrSel.
  localparam int unsigned CAUSE_OVERFLOW  = 0;
  localparam int unsigned CAUSE_LEN_LIMIT = 1;
  localparam int unsigned CAUSE_UNMATCHED = 2;
  localparam int unsigned CAUSE_INACTIVE  = 3;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic clr;      // zero the word
    logic restart;  // load the event, dropping the old total
    logic accum;    // add the event to the total
  } stat_strobe_t;

endpackage

// File: rtl/discard_ctrl.sv
module discard_ctrl
  import discard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtValid,
  input  logic         wrHit,
  input  logic         wrZero,
  output stat_strobe_t stb,
  output logic         evtPulse
);

  logic clearReq;
  assign clearReq = wrHit && wrZero;

  always_comb begin
    stb         = '0;
    stb.restart = evtValid && clearReq;
    stb.accum   = evtValid && !clearReq;
    stb.clr     = !evtValid && clearReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPulse <= 1'b0;
    else       evtPulse <= evtValid;
  end

  AST_PULSE_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> evtPulse);  // R8
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> !evtPulse);  // R8

endmodule

// File: rtl/discard_datapath.sv
module discard_datapath
  import discard_pkg::*;
#(
  parameter int unsigned IN_AMT_W = 16,
  parameter int unsigned ACC_W    = 24,
  parameter int unsigned DT_W     = 6,
  parameter int unsigned VC_W     = 2,
  localparam int unsigned REG_W   = ACC_W + DT_W + VC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  stat_strobe_t        stb,
  input  logic [IN_AMT_W-1:0] evtAmount,
  input  logic [DT_W-1:0]     evtDataType,
  input  logic [VC_W-1:0]     evtVirtChan,
  output logic [REG_W-1:0]    regWord
);

  localparam int unsigned SUM_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] AMT_MAX = {ACC_W{1'b1}};

  logic [ACC_W-1:0] amountQ;
  logic [DT_W-1:0]  dtQ;
  logic [VC_W-1:0]  vcQ;
  logic [ACC_W-1:0] amtExt;
  logic [SUM_W-1:0] sumWide;
  logic [ACC_W-1:0] sumSat;

  assign amtExt  = ACC_W'(evtAmount);
  assign sumWide = SUM_W'(amountQ) + SUM_W'(amtExt);
  assign sumSat  = sumWide[ACC_W] ? AMT_MAX : sumWide[ACC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      amountQ <= '0;
      dtQ     <= '0;
      vcQ     <= '0;
    end else if (stb.clr) begin
      amountQ <= '0;
      dtQ     <= '0;
      vcQ     <= '0;
    end else if (stb.restart || stb.accum) begin
      amountQ <= stb.restart ? amtExt : sumSat;
      dtQ     <= evtDataType;
      vcQ     <= evtVirtChan;
    end
  end

  assign regWord = {vcQ, dtQ, amountQ};

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.accum |=> amountQ >= $past(amountQ));  // R4
  AST_CAPTURE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accum || stb.restart) |=>
      (dtQ == $past(evtDataType)) && (vcQ == $past(evtVirtChan)));  // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> regWord == '0);  // R5
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> amountQ == $past(amtExt));  // R7

endmodule

// File: rtl/discard_stat_bank.sv
module discard_stat_bank
  import discard_pkg::*;
#(
  parameter int unsigned NUM_CAUSES = 4,
  parameter int unsigned IN_AMT_W   = 16,
  parameter int unsigned ACC_W      = 24,
  parameter int unsigned DT_W       = 6,
  parameter int unsigned VC_W       = 2,
  localparam int unsigned SEL_W     = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1,
  localparam int unsigned REG_W     = ACC_W + DT_W + VC_W
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CAUSES-1:0]                evtValid,
  input  logic [NUM_CAUSES-1:0][IN_AMT_W-1:0]  evtAmount,
  input  logic [NUM_CAUSES-1:0][DT_W-1:0]      evtDataType,
  input  logic [NUM_CAUSES-1:0][VC_W-1:0]      evtVirtChan,
  input  logic                                 wrEn,
  input  logic [SEL_W-1:0]                     wrSel,
  input  logic [REG_W-1:0]                     wrData,
  output logic [NUM_CAUSES-1:0][REG_W-1:0]     statRegs,
  output logic [NUM_CAUSES-1:0]                statEvent
);

  logic wrZero;
  assign wrZero = (wrData == '0);

  for (genvar gi = 0; gi < NUM_CAUSES; gi++) begin : g_slot
    stat_strobe_t stb;
    logic         wrHit;

    assign wrHit = wrEn && (wrSel == SEL_W'(gi));

    discard_ctrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .evtValid (evtValid[gi]),
      .wrHit    (wrHit),
      .wrZero   (wrZero),
      .stb      (stb),
      .evtPulse (statEvent[gi])
    );

    discard_datapath #(
      .IN_AMT_W (IN_AMT_W),
      .ACC_W    (ACC_W),
      .DT_W     (DT_W),
      .VC_W     (VC_W)
    ) u_dp (
      .clk         (clk),
      .rstN        (rstN),
      .stb         (stb),
      .evtAmount   (evtAmount[gi]),
      .evtDataType (evtDataType[gi]),
      .evtVirtChan (evtVirtChan[gi]),
      .regWord     (statRegs[gi])
    );

    AST_NONZERO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (wrHit && !wrZero && !evtValid[gi]) |=> $stable(statRegs[gi]));  // R6
    AST_SLOT_ISOLATION: assert property (@(posedge clk) disable iff (!rstN)
      (!wrHit && !evtValid[gi]) |=> $stable(statRegs[gi]));  // R9
  end

endmodule

// File: tb/test_discard_stat_bank.sv
module test_discard_stat_bank;

  localparam int N = 4;
  localparam int MAXV = 32'h00FF_FFFF;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [N-1:0]         evtValid = '0;
  logic [N-1:0][15:0]   evtAmount = '0;
  logic [N-1:0][5:0]    evtDataType = '0;
  logic [N-1:0][1:0]    evtVirtChan = '0;
  logic                 wrEn = 1'b0;
  logic [1:0]           wrSel = '0;
  logic [31:0]          wrData = '0;
  logic [N-1:0][31:0]   statRegs;
  logic [N-1:0]         statEvent;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  int expAmt [N];
  int expDt  [N];
  int expVc  [N];
  logic [N-1:0] expPulse;

  always #5 clk = ~clk;

  discard_stat_bank i_discard_stat_bank (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtAmount(evtAmount),
    .evtDataType(evtDataType), .evtVirtChan(evtVirtChan), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .statRegs(statRegs), .statEvent(statEvent)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Model from the requirements, then one clock, then compare every slot.
  task automatic runCycle(string tag);
    for (int i = 0; i < N; i++) begin
      bit clr = wrEn && (wrSel == i) && (wrData == 0);
      if (evtValid[i]) begin
        if (clr) expAmt[i] = evtAmount[i];
        else expAmt[i] = (expAmt[i] + evtAmount[i] > MAXV) ? MAXV : expAmt[i] + evtAmount[i];
        expDt[i] = evtDataType[i];
        expVc[i] = evtVirtChan[i];
      end else if (clr) begin
        expAmt[i] = 0; expDt[i] = 0; expVc[i] = 0;
      end
      expPulse[i] = evtValid[i];
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      check(tag, statRegs[i], {expVc[i][1:0], expDt[i][5:0], expAmt[i][23:0]});
      check({tag, " R8"}, 32'(statEvent[i]), 32'(expPulse[i]));
    end
    evtValid = '0;
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic setEvt(int s, int amt, int dt, int vc);
    evtValid[s] = 1'b1;
    evtAmount[s] = 16'(amt);
    evtDataType[s] = 6'(dt);
    evtVirtChan[s] = 2'(vc);
  endtask

  task automatic setWr(int s, int data);
    wrEn = 1'b1;
    wrSel = 2'(s);
    wrData = 32'(data);
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin
      check("R1 reset word", statRegs[i], 32'h0);
      check("R1 reset pulse", 32'(statEvent[i]), 32'h0);
      expAmt[i] = 0; expDt[i] = 0; expVc[i] = 0;
    end
  endtask

  task automatic t_accumulate;
    setEvt(1, 100, 6'h2A, 2); runCycle("R2 R3 first add");
    check("R2 field", statRegs[1], {2'd2, 6'h2A, 24'd100});
    runCycle("R8 pulse drops");
    setEvt(1, 16'h0FFF, 6'h12, 1); runCycle("R2 R3 second add");
    check("R3 latest tag", statRegs[1], {2'd1, 6'h12, 24'd4195});
    setEvt(1, 0, 6'h3F, 3); runCycle("R3 zero amount updates tag");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 256; k++) begin
      setEvt(2, 16'hFFFF, 6'h01, 0); runCycle("R2 fill");
    end
    check("R4 below max", statRegs[2], {2'd0, 6'h01, 24'hFFFF00});
    setEvt(2, 16'h00FF, 6'h02, 1); runCycle("R4 exact max");
    check("R4 exact max", statRegs[2], {2'd1, 6'h02, 24'hFFFFFF});
    setEvt(2, 16'h1234, 6'h03, 2); runCycle("R4 held at max");
    check("R4 no wrap", statRegs[2], {2'd2, 6'h03, 24'hFFFFFF});
  endtask

  task automatic t_ignore;
    setWr(2, 32'h0000_1234); runCycle("R6 nonzero write");
    check("R6 unchanged", statRegs[2], {2'd2, 6'h03, 24'hFFFFFF});
    setWr(1, 32'h8000_0000); runCycle("R6 top bit only");
  endtask

  task automatic t_clear;
    setEvt(0, 55, 6'h05, 3); setEvt(3, 9, 6'h07, 1); runCycle("R9 two slots");
    setWr(1, 0); runCycle("R5 R9 clear slot 1");
    check("R5 cleared", statRegs[1], 32'h0);
    check("R9 neighbour kept", statRegs[0], {2'd3, 6'h05, 24'd55});
    setWr(0, 0); setEvt(3, 1, 6'h08, 2); runCycle("R9 clear one, event other");
  endtask

  task automatic t_simultaneous;
    setWr(2, 0); setEvt(2, 7, 6'h05, 1); runCycle("R7 clear with event");
    check("R7 restart value", statRegs[2], {2'd1, 6'h05, 24'd7});
    setEvt(2, 3, 6'h06, 0); runCycle("R7 continues from restart");
  endtask

  initial begin
    expPulse = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_accumulate;
    t_saturate;
    t_ignore;
    t_clear;
    t_simultaneous;
    runCycle("R8 idle");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule